// File: doc/BRIEF.md
# Serial Transceiver with Packed Receive Reads

This block is an asynchronous serial transmitter and receiver with one line format only: eight data bits, no parity bit and a single stop bit. Each direction has a deep ring buffer kept in an inferred RAM. A buffer with 2^AW slots stores at most 2^AW-1 bytes. With the default AW = 10 this is 1023 bytes. Software can therefore let many characters build up at high line rates before it has to act.

Software reaches the block through a small synchronous register port that is 32 bits wide. A write to the data register queues one byte for transmission. A read of the data register returns up to three received bytes in one word, together with a count of the valid bytes. This cuts the bus traffic for each received character. A status register reports the buffer levels and two sticky error flags. A control register enables the two interrupt causes.

The line rate is set by the parameter CLK_DIV, which is the number of clock cycles per tick. One tick is one sixteenth of a bit time.

Top module: `bulk_uart`

## Requirements
- R1: The transmit line idles high. Each character is sent as a low start bit, then the eight data bits with the LSB first, then a high stop bit. Every bit lasts 16 ticks.
- R2: When the transmit buffer still holds bytes at the end of a stop bit, the next start bit begins at once, with no idle time between characters. Two queued characters therefore start 160 ticks apart.
- R3: The receiver passes rxd through a synchronizer and starts a frame only on a high-to-low transition. It checks that the start bit is still low at mid-bit, samples each data bit near its centre with the LSB first, and stores the bytes in the order they arrive.
- R4: A read of the data register (bus_addr = 0) returns the oldest byte in bits [7:0], the next byte in [15:8] and the third in [23:16]. The number of valid bytes, min(fill, 3), is in [25:24]. Byte lanes above that count, and bits [31:26], read as zero.
- R5: A data read removes exactly the bytes it counts. When the receive buffer is empty, a data read returns 0 and changes nothing.
- R6: The receive buffer holds 2^AW-1 bytes. A byte that completes while the buffer is full is dropped and sets the receive-overrun flag (status bit 24). Reading the status register clears that flag.
- R7: A data write pushes bus_wdata[7:0] into the transmit buffer, which holds 2^AW-1 bytes. A write while that buffer is full is discarded and sets the transmit-overflow flag (status bit 25). Reading the status register clears that flag.
- R8: A character whose stop bit is low is still stored as a normal byte. No flag is raised for it.
- R9: A read of the status register (bus_addr = 1) returns the receive fill level in [11:0] and the transmit free space (2^AW-1 minus the fill) in [23:12], with the two flags in bits 24 and 25.
- R10: Control register bit 0 enables the receive interrupt cause and bit 1 enables the transmit cause (bus_addr = 2, readable). irq is high while the receive cause is enabled and the receive buffer is not empty, or while the transmit cause is enabled and the transmit fill is below 2^(AW-1).
- R11: After reset txd is high, irq is low, both buffers are empty, both flags are clear and both interrupt causes are disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 status, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request, level |

## Verification
- **Read-pointer errors.** A read pointer that advances by more or less than the count it reports shows on the next data read. That read holds lost, repeated or reordered bytes, or a count that does not match the fill level in the status register.
- **Transmit state errors.** A wrong bit or tick counter in the transmitter shows within one character time. It appears as a misplaced stop bit, a wrong data bit at the mid-bit sample point, or a gap between queued characters.
- **Full-detection errors.** A full test that is off by one shows only at the buffer limit. It appears as a status word with one byte too many or too few, or as a sticky flag that does not appear after the first dropped byte.

// File: rtl/bulk_uart_pkg.sv
package bulk_uart_pkg;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;

  // bytes one data read may take from a buffer holding `fill`
  function automatic logic [1:0] take_count(input logic [11:0] fill);
    return (fill > 12'd2) ? 2'd3 : fill[1:0];
  endfunction

  // packed receive word: lanes above n forced to zero
  function automatic logic [31:0] pack_rx(input logic [1:0] n,
                                          input logic [7:0] b0,
                                          input logic [7:0] b1,
                                          input logic [7:0] b2);
    return {6'd0, n,
            (n > 2'd2) ? b2 : 8'd0,
            (n > 2'd1) ? b1 : 8'd0,
            (n > 2'd0) ? b0 : 8'd0};
  endfunction

  function automatic logic [31:0] pack_status(input logic [11:0] rx_fill,
                                              input logic [11:0] tx_free,
                                              input logic ovr,
                                              input logic ovf);
    return {6'd0, ovf, ovr, tx_free, rx_fill};
  endfunction

endpackage

// File: rtl/bulk_uart_ring.sv
module bulk_uart_ring #(
  parameter int AW = 10,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic [1:0]    pop_n,
  output logic [W-1:0]  tap0,
  output logic [W-1:0]  tap1,
  output logic [W-1:0]  tap2,
  output logic [AW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int DEPTH = 2 ** AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
    end
  end

  assign count = wr_ptr - rd_ptr;
  assign full  = (count == {AW{1'b1}});
  assign empty = (count == '0);
  assign tap0  = mem[rd_ptr];
  assign tap1  = mem[rd_ptr + AW'(1)];
  assign tap2  = mem[rd_ptr + AW'(2)];
endmodule

// File: rtl/bulk_uart_tx.sv
module bulk_uart_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       have,
  input  logic [7:0] din,
  output logic       load,
  output logic       busy,
  output logic       txd
);
  logic [9:0] shreg;
  logic [3:0] tcnt;
  logic [3:0] bitcnt;
  logic       last_edge;

  assign last_edge = busy && tick && (tcnt == 4'd15) && (bitcnt == 4'd9);
  assign load      = have && (!busy || last_edge);
  assign txd       = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '1;
      tcnt   <= '0;
      bitcnt <= '0;
      busy   <= 1'b0;
    end else if (load) begin
      shreg  <= {1'b1, din, 1'b0};
      tcnt   <= '0;
      bitcnt <= '0;
      busy   <= 1'b1;
    end else if (last_edge) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      tcnt <= tcnt + 4'd1;
      if (tcnt == 4'd15) begin
        shreg  <= {1'b1, shreg[9:1]};
        bitcnt <= bitcnt + 4'd1;
      end
    end
  end
endmodule

// File: rtl/bulk_uart_rx.sv
module bulk_uart_rx
  import bulk_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  output logic       byte_valid,
  output logic [7:0] byte_out
);
  rx_state_e  st;
  logic [2:0] sync;
  logic [3:0] tcnt;
  logic [2:0] bits;
  logic [7:0] sh;
  logic       line, line_prev;

  assign line      = sync[1];
  assign line_prev = sync[2];
  assign byte_out  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync       <= '1;
      st         <= RX_IDLE;
      tcnt       <= '0;
      bits       <= '0;
      sh         <= '0;
      byte_valid <= 1'b0;
    end else begin
      sync       <= {sync[1:0], rxd};
      byte_valid <= 1'b0;
      case (st)
        RX_IDLE: begin
          tcnt <= '0;
          if (!line && line_prev) st <= RX_START;
        end
        RX_START: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd7) begin
            tcnt <= '0;
            bits <= '0;
            st   <= line ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            sh   <= {line, sh[7:1]};
            bits <= bits + 3'd1;
            if (bits == 3'd7) st <= RX_STOP;
          end
        end
        RX_STOP: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (tcnt == 4'd15) begin
            byte_valid <= 1'b1;
            st         <= RX_IDLE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bulk_uart.sv
module bulk_uart
  import bulk_uart_pkg::*;
#(
  parameter int CLK_DIV = 54,
  parameter int AW      = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  localparam int CAP  = 2 ** AW - 1;
  localparam int HALF = 2 ** (AW - 1);
  localparam int DW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  // tick generator: 16 ticks per bit
  logic [DW-1:0] div_cnt;
  logic          tick;
  assign tick = (div_cnt == DW'(CLK_DIV - 1));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_cnt <= '0;
    else if (tick) div_cnt <= '0;
    else           div_cnt <= div_cnt + DW'(1);
  end

  // named events
  logic rd_data, rd_stat, wr_data, wr_ctrl;
  assign rd_data = bus_en && !bus_we && (bus_addr == REG_DATA);
  assign rd_stat = bus_en && !bus_we && (bus_addr == REG_STAT);
  assign wr_data = bus_en &&  bus_we && (bus_addr == REG_DATA);
  assign wr_ctrl = bus_en &&  bus_we && (bus_addr == REG_CTRL);

  // receive path
  logic          rx_valid, rx_push, rx_drop, rx_full, rx_empty;
  logic [7:0]    rx_byte, rx_t0, rx_t1, rx_t2;
  logic [AW-1:0] rx_count;
  logic [1:0]    rx_take;

  bulk_uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .byte_valid(rx_valid), .byte_out(rx_byte)
  );

  assign rx_push = rx_valid && !rx_full;
  assign rx_drop = rx_valid &&  rx_full;
  assign rx_take = rd_data ? take_count(12'(rx_count)) : 2'd0;

  bulk_uart_ring #(.AW(AW), .W(8)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte), .pop_n(rx_take),
    .tap0(rx_t0), .tap1(rx_t1), .tap2(rx_t2),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  // transmit path
  logic          tx_push, tx_drop, tx_full, tx_empty, tx_load, tx_busy;
  logic [7:0]    tx_t0, unused_tx_t1, unused_tx_t2;
  logic [AW-1:0] tx_count;

  assign tx_push = wr_data && !tx_full;
  assign tx_drop = wr_data &&  tx_full;

  bulk_uart_ring #(.AW(AW), .W(8)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[7:0]),
    .pop_n({1'b0, tx_load}),
    .tap0(tx_t0), .tap1(unused_tx_t1), .tap2(unused_tx_t2),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  bulk_uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .have(!tx_empty), .din(tx_t0),
    .load(tx_load), .busy(tx_busy), .txd(txd)
  );

  // sticky flags, interrupt enables, read data
  logic       ovr_flag, ovf_flag;
  logic [1:0] irq_en;
  logic       unused_wdata;
  assign unused_wdata = ^bus_wdata[31:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag  <= 1'b0;
      ovf_flag  <= 1'b0;
      irq_en    <= 2'b00;
      bus_rdata <= '0;
    end else begin
      if (rd_stat) begin
        ovr_flag <= 1'b0;
        ovf_flag <= 1'b0;
      end
      if (rx_drop) ovr_flag <= 1'b1;
      if (tx_drop) ovf_flag <= 1'b1;
      if (wr_ctrl) irq_en <= bus_wdata[1:0];
      if (bus_en && !bus_we) begin
        case (bus_addr)
          REG_DATA: bus_rdata <= pack_rx(rx_take, rx_t0, rx_t1, rx_t2);
          REG_STAT: bus_rdata <= pack_status(12'(rx_count), 12'(CAP - 32'(tx_count)),
                                             ovr_flag, ovf_flag);
          REG_CTRL: bus_rdata <= {30'd0, irq_en};
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  assign irq = (irq_en[0] && !rx_empty) ||
               (irq_en[1] && (32'(tx_count) < HALF));
endmodule

// File: rtl/bulk_uart_chk.sv
module bulk_uart_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          irq,
  input logic          tx_busy,
  input logic [AW-1:0] rx_count,
  input logic [1:0]    rx_take,
  input logic          rx_push,
  input logic          rx_drop,
  input logic          tx_drop,
  input logic          ovr_flag,
  input logic          ovf_flag,
  input logic [1:0]    irq_en
);
  p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  p_no_push_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (rx_count != {AW{1'b1}}));

  p_drop_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> ovr_flag);

  p_take_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(rx_take) <= rx_count);

  p_rx_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rx_count == $past(rx_count) + AW'($past(rx_push)) - AW'($past(rx_take)));

  p_tx_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_drop |=> ovf_flag);

  p_irq_rx_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[0] && rx_count != '0) |-> irq);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> !irq);
endmodule

bind bulk_uart bulk_uart_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .irq(irq), .tx_busy(tx_busy),
  .rx_count(rx_count), .rx_take(rx_take), .rx_push(rx_push), .rx_drop(rx_drop),
  .tx_drop(tx_drop), .ovr_flag(ovr_flag), .ovf_flag(ovf_flag), .irq_en(irq_en)
);

// File: tb/bulk_uart_tb.sv
`timescale 1ns/1ps
module bulk_uart_tb;
  localparam int CLK_DIV = 2;
  localparam int AW      = 4;
  localparam int CAP     = 2 ** AW - 1;
  localparam int BIT     = 16 * CLK_DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        txd, irq;
  logic        loop = 1'b0;
  logic        drv = 1'b1;
  logic        rxd;

  assign rxd = loop ? txd : drv;

  bulk_uart #(.CLK_DIV(CLK_DIV), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  always #5 clk = ~clk;

  int errors = 0, total = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_en = 1'b0; d = bus_rdata;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); drv = fr[i];
      repeat (BIT - 1) @(negedge clk);
    end
    @(negedge clk); drv = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected data word built lane by lane
  function automatic logic [31:0] exp_word(input int n, input logic [7:0] a,
                                           input logic [7:0] b, input logic [7:0] c);
    logic [31:0] w;
    logic [7:0] lanes [3];
    lanes = '{a, b, c};
    w = 32'(n) << 24;
    for (int i = 0; i < n; i++) w = w | (32'(lanes[i]) << (8 * i));
    return w;
  endfunction

  function automatic logic [31:0] exp_stat(input int fill, input int free,
                                           input bit ovr, input bit ovf);
    return (32'(ovf) << 25) | (32'(ovr) << 24) | (32'(free) << 12) | 32'(fill);
  endfunction

  // capture one frame on txd: returns byte, start/stop levels and fall cycle
  task automatic tx_capture(output logic [7:0] b, output logic st, output logic sp,
                            output int fall);
    int guard;
    guard = 0;
    while (txd !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
    fall = cyc;
    wait_cyc(BIT / 2);
    st = txd;
    for (int i = 0; i < 8; i++) begin wait_cyc(BIT); b[i] = txd; end
    wait_cyc(BIT);
    sp = txd;
  endtask

  localparam int NV = 4;
  localparam int VN [NV] = '{1, 2, 3, 4};
  localparam logic [7:0] VB [NV][4] = '{
    '{8'h41, 8'h00, 8'h00, 8'h00},
    '{8'hFF, 8'h00, 8'h00, 8'h00},
    '{8'h01, 8'h80, 8'h7E, 8'h00},
    '{8'hDE, 8'hAD, 8'hBE, 8'hEF}
  };

  initial begin
    logic [31:0] r;
    logic [7:0]  b1, b2;
    logic        st1, sp1, st2, sp2;
    int          f1, f2;

    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);

    // R11 reset state
    check("R11 txd idle", 32'(txd), 32'd1);
    check("R11 irq low", 32'(irq), 32'd0);
    bus_read(2'd1, r); check("R11 R9 status after reset", r, exp_stat(0, CAP, 0, 0));
    bus_read(2'd2, r); check("R11 enables clear", r, 32'd0);
    bus_read(2'd0, r); check("R11 R5 empty data read", r, 32'd0);

    // vector table: loopback, packed reads (R3 R4 R5)
    loop = 1'b1;
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < VN[v]; k++) bus_write(2'd0, {24'hABCDEF, VB[v][k]});
      wait_cyc(VN[v] * 10 * BIT + 200);
      bus_read(2'd1, r); check("R9 fill after loopback", r, exp_stat(VN[v], CAP, 0, 0));
      bus_read(2'd0, r);
      check("R3 R4 packed word", r,
            exp_word((VN[v] > 3) ? 3 : VN[v], VB[v][0], VB[v][1], VB[v][2]));
      if (VN[v] > 3) begin
        bus_read(2'd0, r); check("R5 remainder word", r, exp_word(1, VB[v][3], 8'h00, 8'h00));
      end
      bus_read(2'd0, r); check("R5 drained", r, 32'd0);
    end
    loop = 1'b0;
    wait_cyc(50);

    // R1 R2 frame shape and back-to-back timing
    bus_write(2'd0, 32'h3C);
    bus_write(2'd0, 32'hC5);
    tx_capture(b1, st1, sp1, f1);
    tx_capture(b2, st2, sp2, f2);
    check("R1 first byte LSB first", 32'(b1), 32'h3C);
    check("R1 start low stop high", {30'd0, st1, sp1}, 32'h1);
    check("R1 second byte", 32'(b2), 32'hC5);
    check("R1 second frame bits", {30'd0, st2, sp2}, 32'h1);
    check("R2 no gap between frames", 32'((f2 - f1 >= 10 * BIT - 2) && (f2 - f1 <= 10 * BIT + 1)), 32'd1);
    wait_cyc(BIT * 2);
    check("R1 idle after frames", 32'(txd), 32'd1);

    // R8 missing stop bit still stored, no flag
    send_byte(8'h5A, 1'b0);
    wait_cyc(BIT * 2);
    bus_read(2'd0, r); check("R8 byte kept", r, exp_word(1, 8'h5A, 8'h00, 8'h00));
    bus_read(2'd1, r); check("R8 no flag", r, exp_stat(0, CAP, 0, 0));

    // R6 overrun: CAP+1 bytes with no reads
    for (int i = 0; i <= CAP; i++) send_byte(8'h10 + 8'(i), 1'b1);
    wait_cyc(20);
    bus_read(2'd1, r); check("R6 full and overrun", r, exp_stat(CAP, CAP, 1, 0));
    bus_read(2'd1, r); check("R6 overrun cleared by read", r, exp_stat(CAP, CAP, 0, 0));
    for (int g = 0; g < CAP / 3; g++) begin
      bus_read(2'd0, r);
      check("R6 R4 order kept", r, exp_word(3, 8'h10 + 8'(3 * g), 8'h11 + 8'(3 * g), 8'h12 + 8'(3 * g)));
    end
    bus_read(2'd0, r); check("R6 last byte dropped", r, 32'd0);

    // R10 receive cause
    bus_write(2'd2, 32'h1);
    wait_cyc(1);
    check("R10 rx cause idle", 32'(irq), 32'd0);
    send_byte(8'h99, 1'b1);
    wait_cyc(10);
    check("R10 rx cause raised", 32'(irq), 32'd1);
    bus_read(2'd0, r);
    check("R10 rx cause cleared", 32'(irq), 32'd0);

    // R7 transmit overflow, R10 transmit cause
    bus_write(2'd2, 32'h2);
    bus_read(2'd2, r); check("R10 ctrl readback", r, 32'h2);
    check("R10 tx cause empty", 32'(irq), 32'd1);
    for (int i = 0; i < CAP + 2; i++) bus_write(2'd0, 32'h60 + 32'(i));
    check("R10 tx cause above half", 32'(irq), 32'd0);
    bus_read(2'd1, r); check("R7 tx full and overflow", r, exp_stat(0, 0, 0, 1));
    bus_read(2'd1, r); check("R7 overflow cleared", r, exp_stat(0, 0, 0, 0));
    wait_cyc((CAP + 2) * 10 * BIT);
    bus_read(2'd1, r); check("R7 tx drained", r, exp_stat(0, CAP, 0, 0));
    check("R10 tx cause back", 32'(irq), 32'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end
endmodule